// File: doc/BRIEF.md
# Interrupt Eligibility and Privilege Routing

This block decides, within a single combinational pass, whether any pending interrupt may be taken now and at which privilege level the handler must run. It receives the pending and enable masks and the delegation mask. It also receives the hart's current privilege, the three per-level global enable bits, and three strap bits. The straps say whether the supervisor level, the user level and user-level interrupt handling are implemented. From these inputs it reports whether an interrupt is taken, the group of interrupt bits being taken, the cause code of the most urgent bit in that group, and the privilege level that receives it.

Interrupts that are not delegated are considered first and always go to machine level. Delegated interrupts are considered only when no machine-level interrupt can be taken. If the supervisor level exists, they go to supervisor level. If it does not, they go to user level. Two system shapes need no routing, because no level below machine can take a trap: a hart without a user level, and a hart that has neither a supervisor level nor user-level interrupt handling. For these shapes the delegation mask is ignored and everything is taken at machine level. The trap entry sequence and the return instructions sit in the surrounding core.

Top module: `irq_route_top`

## Requirements
- R1: The enabled pending set is the bitwise AND of pendBits and enBits. When no interrupt is taken, irqValid, irqSet, irqCause and irqTarget are all zero.
- R2: The machine enable holds whenever curPriv is below machine, or when curPriv is machine and mEnBit is 1. Non-delegated enabled pending bits are never taken while this enable is low.
- R3: The supervisor enable holds only when hasSup is 1 and either curPriv is user, or curPriv is supervisor with sEnBit set. Delegated interrupts are never taken from machine privilege.
- R4: The user enable holds only when hasUserIrq is 1, curPriv is user and uEnBit is 1.
- R5: If the machine enable holds and some enabled pending bit is not delegated, then irqTarget is machine. In that case irqSet holds exactly the enabled pending bits that are not delegated.
- R6: If no non-delegated bit can be taken, the enabled pending bits that are delegated are considered next. With hasSup set, they are taken at supervisor level when the supervisor enable holds. irqSet then holds exactly those delegated bits.
- R7: With hasSup clear (and no shortcut per R8), delegated enabled pending bits are taken at user level only when the user enable holds. Otherwise nothing is taken.
- R8: When hasUsr is 0, or when hasSup and hasUserIrq are both 0, delegBits has no effect. All enabled pending bits are then taken at machine level, subject only to the machine enable.
- R9: Bit positions of the 12-bit masks and cause codes: user software 0, supervisor software 1, machine software 3, user timer 4, supervisor timer 5, machine timer 7, user external 8, supervisor external 9, machine external 11. irqCause is the position of the most urgent bit of irqSet. Urgency from highest to lowest: machine external, machine software, machine timer, supervisor external, supervisor software, supervisor timer, user external, user software, user timer.
- R10: Privilege encoding on curPriv and irqTarget: user 2'b00, supervisor 2'b01, machine 2'b11. A taken interrupt never targets a level below curPriv.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pendBits | input | 12 | Raw pending interrupt bits |
| enBits | input | 12 | Per-interrupt enable bits |
| delegBits | input | 12 | Machine-to-lower delegation mask |
| curPriv | input | 2 | Current privilege level |
| mEnBit | input | 1 | Machine global interrupt enable |
| sEnBit | input | 1 | Supervisor global interrupt enable |
| uEnBit | input | 1 | User global interrupt enable |
| hasSup | input | 1 | Supervisor level implemented |
| hasUsr | input | 1 | User level implemented |
| hasUserIrq | input | 1 | User-level interrupt handling implemented |
| irqValid | output | 1 | An interrupt is taken |
| irqSet | output | 12 | Group of interrupt bits being taken |
| irqCause | output | 4 | Cause code of the most urgent bit in irqSet |
| irqTarget | output | 2 | Privilege level that takes the interrupt |

## Verification
The immediate assertions hold for every input combination. They check that a taken set is non-empty and lies inside the enabled pending bits. They also check that the reported cause bit belongs to the set, that a machine-level pick never mixes in delegated bits unless delegation is being ignored, and that the target never drops below the current privilege. The assertions cannot see the enable derivation for each level, the fallthrough from blocked machine bits to delegated ones, the two no-delegation system shapes, or the urgency order among bits in the same group. Those behaviours are covered only by the bench's vectors, which pin down the exact set, cause and target for each chosen privilege and strap combination.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

  localparam int IRQ_BITS   = 12;
  localparam int CAUSE_BITS = 4;
  localparam int NUM_SRC    = 9;

  typedef enum logic [1:0] {
    PRIV_U = 2'b00,
    PRIV_S = 2'b01,
    PRIV_M = 2'b11
  } priv_e;

  // control -> datapath strobes
  typedef struct packed {
    logic  ignoreDeleg;
    logic  machOpen;
    logic  delegOpen;
    priv_e delegTarget;
  } route_strb_t;

  // urgency rank 0 (highest) .. NUM_SRC-1 mapped to bit position / cause code
  function automatic logic [3:0] srcCode(input int rank);
    case (rank)
      0:       srcCode = 4'd11;
      1:       srcCode = 4'd3;
      2:       srcCode = 4'd7;
      3:       srcCode = 4'd9;
      4:       srcCode = 4'd1;
      5:       srcCode = 4'd5;
      6:       srcCode = 4'd8;
      7:       srcCode = 4'd0;
      8:       srcCode = 4'd4;
      default: srcCode = 4'd0;
    endcase
  endfunction

endpackage

// File: rtl/irq_route_ctrl.sv
module irq_route_ctrl
  import irq_route_pkg::*;
(
  input  logic [1:0]  curPriv,
  input  logic        mEnBit,
  input  logic        sEnBit,
  input  logic        uEnBit,
  input  logic        hasSup,
  input  logic        hasUsr,
  input  logic        hasUserIrq,
  output route_strb_t strb
);

  logic machEn;
  logic supEn;
  logic usrEn;
  logic noRouting;

  always_comb begin
    machEn    = (curPriv != PRIV_M) || mEnBit;
    supEn     = hasSup && ((curPriv == PRIV_U) || ((curPriv == PRIV_S) && sEnBit));
    usrEn     = hasUserIrq && (curPriv == PRIV_U) && uEnBit;
    noRouting = !hasUsr || (!hasSup && !hasUserIrq);

    strb.ignoreDeleg = noRouting;
    strb.machOpen    = machEn;
    strb.delegOpen   = !noRouting && (hasSup ? supEn : usrEn);
    strb.delegTarget = hasSup ? PRIV_S : PRIV_U;
  end

  always_comb begin
    // R2
    lower_priv_mach_open_chk: assert (curPriv == PRIV_M || strb.machOpen);
    // R3
    no_deleg_from_machine_chk: assert (!(strb.delegOpen && curPriv == PRIV_M));
    // R8
    shortcut_blocks_deleg_chk: assert (!(strb.ignoreDeleg && strb.delegOpen));
  end

endmodule

// File: rtl/irq_route_dp.sv
module irq_route_dp
  import irq_route_pkg::*;
#(
  parameter int IRQ_W   = IRQ_BITS,
  parameter int CAUSE_W = CAUSE_BITS
) (
  input  logic [IRQ_W-1:0]   pendBits,
  input  logic [IRQ_W-1:0]   enBits,
  input  logic [IRQ_W-1:0]   delegBits,
  input  route_strb_t        strb,
  output logic               irqValid,
  output logic [IRQ_W-1:0]   irqSet,
  output logic [CAUSE_W-1:0] irqCause,
  output logic [1:0]         irqTarget
);

  logic [IRQ_W-1:0] effPend;
  logic [IRQ_W-1:0] machPend;
  logic [IRQ_W-1:0] delPend;
  logic [IRQ_W-1:0] delegMask;

  // per-bit masking
  for (genvar b = 0; b < IRQ_W; b++) begin : g_mask
    assign effPend[b]   = pendBits[b] & enBits[b];
    assign delegMask[b] = delegBits[b] & ~strb.ignoreDeleg;
    assign machPend[b]  = effPend[b] & ~delegMask[b];
    assign delPend[b]   = effPend[b] & delegMask[b];
  end

  always_comb begin
    irqValid  = 1'b0;
    irqSet    = '0;
    irqTarget = PRIV_U;
    if (strb.machOpen && |machPend) begin
      irqValid  = 1'b1;
      irqSet    = machPend;
      irqTarget = PRIV_M;
    end else if (strb.delegOpen && |delPend) begin
      irqValid  = 1'b1;
      irqSet    = delPend;
      irqTarget = strb.delegTarget;
    end
  end

  // priority pick: walk from least to most urgent, last hit wins
  always_comb begin
    logic [3:0] code;
    irqCause = '0;
    for (int r = NUM_SRC - 1; r >= 0; r--) begin
      code = srcCode(r);
      if (irqSet[code]) irqCause = CAUSE_W'(code);
    end
  end

  always_comb begin
    // R1
    set_inside_enabled_chk: assert (!irqValid || (irqSet != '0 && (irqSet & ~effPend) == '0));
    // R9
    cause_in_set_chk: assert (!irqValid || irqSet[irqCause]);
    // R5
    mach_pick_undelegated_chk: assert (!(irqValid && irqTarget == PRIV_M && !strb.ignoreDeleg)
                                       || (irqSet & delegBits) == '0);
  end

endmodule

// File: rtl/irq_route_top.sv
module irq_route_top
  import irq_route_pkg::*;
#(
  parameter int IRQ_W   = IRQ_BITS,
  parameter int CAUSE_W = CAUSE_BITS
) (
  input  logic [IRQ_W-1:0]   pendBits,
  input  logic [IRQ_W-1:0]   enBits,
  input  logic [IRQ_W-1:0]   delegBits,
  input  logic [1:0]         curPriv,
  input  logic               mEnBit,
  input  logic               sEnBit,
  input  logic               uEnBit,
  input  logic               hasSup,
  input  logic               hasUsr,
  input  logic               hasUserIrq,
  output logic               irqValid,
  output logic [IRQ_W-1:0]   irqSet,
  output logic [CAUSE_W-1:0] irqCause,
  output logic [1:0]         irqTarget
);

  route_strb_t strb;

  irq_route_ctrl u_ctrl (
    .curPriv    (curPriv),
    .mEnBit     (mEnBit),
    .sEnBit     (sEnBit),
    .uEnBit     (uEnBit),
    .hasSup     (hasSup),
    .hasUsr     (hasUsr),
    .hasUserIrq (hasUserIrq),
    .strb       (strb)
  );

  irq_route_dp #(.IRQ_W(IRQ_W), .CAUSE_W(CAUSE_W)) u_dp (
    .pendBits  (pendBits),
    .enBits    (enBits),
    .delegBits (delegBits),
    .strb      (strb),
    .irqValid  (irqValid),
    .irqSet    (irqSet),
    .irqCause  (irqCause),
    .irqTarget (irqTarget)
  );

  always_comb begin
    // R10
    target_not_lower_chk: assert (!irqValid || irqTarget >= curPriv);
    // R1
    idle_outputs_zero_chk: assert (irqValid || (irqSet == '0 && irqCause == '0 && irqTarget == '0));
  end

endmodule

// File: tb/tb_irq_route_top.sv
module tb_irq_route_top;

  typedef struct packed {
    bit [23:0]   tag;
    logic [11:0] pend;
    logic [11:0] en;
    logic [11:0] deleg;
    logic [1:0]  priv;
    logic        me, se, ue, hs, hu, hn;
    logic        v;
    logic [1:0]  tgt;
    logic [3:0]  cause;
    logic [11:0] set;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VECS [NV] = '{
    '{"R5",  12'h888, 12'hFFF, 12'h000, 2'd3, 1'b1,1'b0,1'b0, 1'b1,1'b1,1'b1, 1'b1, 2'd3, 4'd11, 12'h888},
    '{"R2",  12'h888, 12'hFFF, 12'h000, 2'd3, 1'b0,1'b0,1'b0, 1'b1,1'b1,1'b1, 1'b0, 2'd0, 4'd0,  12'h000},
    '{"R9",  12'h088, 12'hFFF, 12'h000, 2'd3, 1'b1,1'b0,1'b0, 1'b1,1'b1,1'b1, 1'b1, 2'd3, 4'd3,  12'h088},
    '{"R3",  12'h222, 12'hFFF, 12'h222, 2'd1, 1'b0,1'b1,1'b0, 1'b1,1'b1,1'b1, 1'b1, 2'd1, 4'd9,  12'h222},
    '{"R3",  12'h222, 12'hFFF, 12'h222, 2'd1, 1'b0,1'b0,1'b0, 1'b1,1'b1,1'b1, 1'b0, 2'd0, 4'd0,  12'h000},
    '{"R3",  12'h222, 12'hFFF, 12'h222, 2'd0, 1'b0,1'b0,1'b0, 1'b1,1'b1,1'b1, 1'b1, 2'd1, 4'd9,  12'h222},
    '{"R1",  12'h022, 12'h020, 12'h222, 2'd0, 1'b0,1'b0,1'b0, 1'b1,1'b1,1'b1, 1'b1, 2'd1, 4'd5,  12'h020},
    '{"R2",  12'h802, 12'hFFF, 12'h002, 2'd1, 1'b0,1'b1,1'b0, 1'b1,1'b1,1'b1, 1'b1, 2'd3, 4'd11, 12'h800},
    '{"R6",  12'h802, 12'h002, 12'h002, 2'd1, 1'b0,1'b1,1'b0, 1'b1,1'b1,1'b1, 1'b1, 2'd1, 4'd1,  12'h002},
    '{"R3",  12'h802, 12'hFFF, 12'h002, 2'd3, 1'b0,1'b1,1'b0, 1'b1,1'b1,1'b1, 1'b0, 2'd0, 4'd0,  12'h000},
    '{"R7",  12'h111, 12'hFFF, 12'h111, 2'd0, 1'b0,1'b0,1'b1, 1'b0,1'b1,1'b1, 1'b1, 2'd0, 4'd8,  12'h111},
    '{"R7",  12'h111, 12'hFFF, 12'h111, 2'd0, 1'b0,1'b0,1'b0, 1'b0,1'b1,1'b1, 1'b0, 2'd0, 4'd0,  12'h000},
    '{"R8",  12'h010, 12'hFFF, 12'hFFF, 2'd0, 1'b0,1'b0,1'b0, 1'b0,1'b1,1'b0, 1'b1, 2'd3, 4'd4,  12'h010},
    '{"R8",  12'h202, 12'hFFF, 12'h202, 2'd3, 1'b1,1'b0,1'b0, 1'b1,1'b0,1'b1, 1'b1, 2'd3, 4'd9,  12'h202},
    '{"R8",  12'h202, 12'hFFF, 12'h202, 2'd3, 1'b0,1'b0,1'b0, 1'b1,1'b0,1'b1, 1'b0, 2'd0, 4'd0,  12'h000},
    '{"R9",  12'h011, 12'hFFF, 12'h011, 2'd0, 1'b0,1'b0,1'b1, 1'b0,1'b1,1'b1, 1'b1, 2'd0, 4'd0,  12'h011},
    '{"R9",  12'h022, 12'hFFF, 12'h022, 2'd0, 1'b0,1'b0,1'b0, 1'b1,1'b1,1'b1, 1'b1, 2'd1, 4'd1,  12'h022},
    '{"R1",  12'hFFF, 12'h000, 12'h000, 2'd3, 1'b1,1'b1,1'b1, 1'b1,1'b1,1'b1, 1'b0, 2'd0, 4'd0,  12'h000},
    '{"R4",  12'h100, 12'hFFF, 12'h100, 2'd3, 1'b0,1'b0,1'b1, 1'b0,1'b1,1'b1, 1'b0, 2'd0, 4'd0,  12'h000}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [11:0] pendBits, enBits, delegBits;
  logic [1:0]  curPriv;
  logic        mEnBit, sEnBit, uEnBit, hasSup, hasUsr, hasUserIrq;
  logic        irqValid;
  logic [11:0] irqSet;
  logic [3:0]  irqCause;
  logic [1:0]  irqTarget;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  irq_route_top dut (
    .pendBits(pendBits), .enBits(enBits), .delegBits(delegBits), .curPriv(curPriv),
    .mEnBit(mEnBit), .sEnBit(sEnBit), .uEnBit(uEnBit),
    .hasSup(hasSup), .hasUsr(hasUsr), .hasUserIrq(hasUserIrq),
    .irqValid(irqValid), .irqSet(irqSet), .irqCause(irqCause), .irqTarget(irqTarget)
  );

  task automatic apply(input vec_t t);
    @(negedge clk);
    pendBits = t.pend; enBits = t.en; delegBits = t.deleg; curPriv = t.priv;
    mEnBit = t.me; sEnBit = t.se; uEnBit = t.ue;
    hasSup = t.hs; hasUsr = t.hu; hasUserIrq = t.hn;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic expect_out(input string req, input logic v, input logic [1:0] tgt,
                            input logic [3:0] cause, input logic [11:0] set);
    total++;
    if (irqValid !== v || irqTarget !== tgt || irqCause !== cause || irqSet !== set) begin
      bad++;
      $display("FAIL %s: actual v=%0b tgt=%0d cause=%0d set=%h expected v=%0b tgt=%0d cause=%0d set=%h",
               req, irqValid, irqTarget, irqCause, irqSet, v, tgt, cause, set);
    end
  endtask

  initial begin
    pendBits = '0; enBits = '0; delegBits = '0; curPriv = 2'd3;
    mEnBit = 0; sEnBit = 0; uEnBit = 0; hasSup = 1; hasUsr = 1; hasUserIrq = 1;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: idle state after reset, nothing pending
    expect_out("R1", 1'b0, 2'd0, 4'd0, 12'h000);

    for (int i = 0; i < NV; i++) begin
      apply(VECS[i]);
      expect_out($sformatf("%s", VECS[i].tag), VECS[i].v, VECS[i].tgt, VECS[i].cause, VECS[i].set);
    end

    // R10: supervisor target encoding from user privilege, never below current
    apply('{"R10", 12'h020, 12'hFFF, 12'h020, 2'd0, 1'b0,1'b0,1'b0, 1'b1,1'b1,1'b1,
            1'b1, 2'd1, 4'd5, 12'h020});
    expect_out("R10", 1'b1, 2'd1, 4'd5, 12'h020);

    // R8: shortcut ignores delegation even with every bit delegated, M-mode MIE set
    apply('{"R8", 12'h0A0, 12'hFFF, 12'hFFF, 2'd3, 1'b1,1'b0,1'b0, 1'b0,1'b1,1'b0,
            1'b1, 2'd3, 4'd7, 12'h0A0});
    expect_out("R8", 1'b1, 2'd3, 4'd7, 12'h0A0);

    // R5: only non-delegated bits in the machine pick, MIE set in M mode
    apply('{"R5", 12'h82A, 12'hFFF, 12'h022, 2'd3, 1'b1,1'b1,1'b1, 1'b1,1'b1,1'b1,
            1'b1, 2'd3, 4'd11, 12'h808});
    expect_out("R5", 1'b1, 2'd3, 4'd11, 12'h808);

    // R9: every source pending, M picks machine external first
    apply('{"R9", 12'hBBB, 12'hFFF, 12'h000, 2'd0, 1'b0,1'b0,1'b0, 1'b1,1'b1,1'b1,
            1'b1, 2'd3, 4'd11, 12'hBBB});
    expect_out("R9", 1'b1, 2'd3, 4'd11, 12'hBBB);

    // R9: all user sources delegated, timer and software: software wins
    apply('{"R9", 12'h011, 12'hFFF, 12'h011, 2'd0, 1'b0,1'b0,1'b0, 1'b1,1'b1,1'b1,
            1'b1, 2'd1, 4'd0, 12'h011});
    expect_out("R9", 1'b1, 2'd1, 4'd0, 12'h011);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule